// File: doc/BRIEF.md
# Dependency Completion Signalling Hub

This block sits between the execution cores of a chiplet and the per-cluster dependency-counter matrices. Every (core, cluster) pair owns two queues: a completion-token queue that the core fills when it finishes a task, and a descriptor queue that holds the signalling fields of the tasks handed to that pair. Pair number p is `core + cluster * N_CORES`. When a descriptor reaches the head of its queue and its completion is present, the descriptor is consumed. Its signalling fields then decide whether the completion increments counters in this chiplet, is forwarded to other chiplets, or both. Synchronisation-only (dummy) descriptors never wait for a completion.

Local signals from all pairs, plus one input carrying signals that arrive from remote chiplets, go through one round-robin arbiter. The winner is driven for one cycle as a one-hot column strobe per cluster, together with the row bitmask. The matrix always accepts. Signals bound for other chiplets go through a second round-robin arbiter into a registered valid/ready port. The bus master beyond that port is a separate block.

Each descriptor is `N_CORES + log2(N_CLUSTERS) + CHIP_W + 3` bits wide (16 bits at the defaults). Counting from bit 0 upward, the fields are:
- row mask, `N_CORES` bits
- target cluster
- target chiplet, `CHIP_W` bits
- broadcast flag
- set-enable flag
- dummy flag

Top module: `dep_signal_hub`

## Requirements
- R1: After reset, `set_col_en_o` is all zero, `set_mask_o` is zero, `rem_valid_o` is 0, and every `done_ready_o` and `chk_ready_o` bit is 1.
- R2: A normal descriptor (bit 15 = 0) of pair p is consumed only while pair p holds at least one completion token, and consuming it removes exactly one token.
- R3: A pair with a normal descriptor and no token does not delay consumption or signalling for any other pair.
- R4: A dummy descriptor (bit 15 = 1) is consumed without a completion token and leaves the pair's token count unchanged.
- R5: A descriptor with set-enable (bit 14) equal to 0 is consumed (taking a token if normal) and causes no local strobe and no remote transfer, whatever its other fields hold.
- R6: A local target (bits 12:5 equal to `chip_id_i`, bit 13 = 0, bit 14 = 1) from pair p with core c yields exactly one cycle in which `set_col_en_o` has only bit `cluster*N_CORES + c` set, where `cluster` is bit 4. In that cycle `set_mask_o` equals bits 3:0.
- R7: A target chiplet different from `chip_id_i` (bit 13 = 0) yields one remote transfer carrying chip = bits 12:5, all = 0, cluster = bit 4, source core c, and mask = bits 3:0. While `rem_ready_i` is low, `rem_valid_o` and the fields stay unchanged.
- R8: Broadcast (bit 13 = 1) yields both a local strobe as in R6 and a remote transfer with `rem_all_o` = 1.
- R9: An incoming remote signal (`in_valid_i`) is accepted through `in_ready_o` and yields a strobe on bit `in_cluster_i*N_CORES + in_col_i` with `set_mask_o = in_mask_i`.
- R10: At most one strobe bit is set per cycle. A pending request is held until granted. With all pairs and the incoming input requesting at once, each of the `N_CORES*N_CLUSTERS + 1` inputs is granted exactly once in the next `N_CORES*N_CLUSTERS + 1` grants.
- R11: `done_ready_o[p]` is 0 exactly while pair p holds `DONE_DEPTH` tokens, and returns to 1 once tokens are consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_id_i | input | CHIP_W | Identity of this chiplet |
| done_valid_i | input | N_CORES*N_CLUSTERS | Completion token push, one bit per pair |
| done_ready_o | output | N_CORES*N_CLUSTERS | Token queue has room, per pair |
| chk_valid_i | input | N_CORES*N_CLUSTERS | Descriptor push, per pair |
| chk_data_i | input | N_CORES*N_CLUSTERS*DW | Descriptors, pair p in slice p*DW |
| chk_ready_o | output | N_CORES*N_CLUSTERS | Descriptor queue has room, per pair |
| in_valid_i | input | 1 | Incoming remote signal valid |
| in_ready_o | output | 1 | Incoming remote signal granted |
| in_cluster_i | input | log2(N_CLUSTERS) | Incoming target cluster |
| in_col_i | input | log2(N_CORES) | Incoming source column |
| in_mask_i | input | N_CORES | Incoming row mask |
| set_col_en_o | output | N_CORES*N_CLUSTERS | One-hot column strobe, bit cluster*N_CORES+column |
| set_mask_o | output | N_CORES | Row mask for the strobed column |
| rem_valid_o | output | 1 | Remote transfer valid |
| rem_ready_i | input | 1 | Remote transfer accepted |
| rem_chip_o | output | CHIP_W | Remote target chiplet |
| rem_all_o | output | 1 | Deliver to every chiplet |
| rem_cluster_o | output | log2(N_CLUSTERS) | Remote target cluster |
| rem_col_o | output | log2(N_CORES) | Source core column |
| rem_mask_o | output | N_CORES | Remote row mask |

## Verification
Every cycle, the assertions check that the strobe is one-hot or idle and that each arbiter grants only requesters, one at a time. They also check that held requests and the stalled remote port keep their contents, that token counts stay within bounds, and that a dummy pop leaves the count alone. Only the directed scenarios can show the end-to-end behaviour: which descriptor waits for which token, that a blocked pair leaves the others free, and that disabled or dummy descriptors consume tokens correctly. They also show the field-to-strobe mapping, the broadcast split, and that every input is served once per round.

// File: rtl/dsh_pkg.sv
package dsh_pkg;
  // Descriptor field offsets, LSB first: mask, cluster, chip, bcast, enable, dummy
  function automatic int f_cl(int nc);
    return nc;
  endfunction
  function automatic int f_chip(int nc, int clw);
    return nc + clw;
  endfunction
  function automatic int f_bc(int nc, int clw, int chw);
    return nc + clw + chw;
  endfunction
  function automatic int f_dw(int nc, int clw, int chw);
    return nc + clw + chw + 3;
  endfunction
endpackage

// File: rtl/dsh_fifo.sv
module dsh_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en && !full) wp <= wp + 1'b1;
      if (rd_en && !empty) rp <= rp + 1'b1;
      if ((wr_en && !full) && !(rd_en && !empty)) cnt <= cnt + 1'b1;
      else if (!(wr_en && !full) && (rd_en && !empty)) cnt <= cnt - 1'b1;
    end
  end

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
endmodule

// File: rtl/dsh_rr.sv
module dsh_rr #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last;
  logic [IW-1:0] sel;
  logic          found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = int'(last) + 1 + i;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
        sel      = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last <= IW'(N - 1);
    else if (adv && found) last <= sel;
  end

  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  assert_grant_to_requester_R10: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);
endmodule

// File: rtl/dsh_lane.sv
module dsh_lane #(
  parameter int NC         = 4,
  parameter int CLW        = 1,
  parameter int CHW        = 8,
  parameter int DONE_DEPTH = 4,
  parameter int CHK_DEPTH  = 4,
  parameter int DW         = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CHW-1:0]  chip_id,
  input  logic            done_valid,
  output logic            done_ready,
  input  logic            chk_valid,
  input  logic [DW-1:0]   chk_data,
  output logic            chk_ready,
  output logic            lreq,
  output logic [CLW-1:0]  lcl,
  output logic [NC-1:0]   lmask,
  input  logic            lgnt,
  output logic            rreq,
  output logic [CHW-1:0]  rchip,
  output logic            rall,
  output logic [CLW-1:0]  rcl,
  output logic [NC-1:0]   rmask,
  input  logic            rgnt
);
  localparam int CNTW   = $clog2(DONE_DEPTH + 1);
  localparam int CL_LSB = dsh_pkg::f_cl(NC);
  localparam int CH_LSB = dsh_pkg::f_chip(NC, CLW);
  localparam int BC_BIT = dsh_pkg::f_bc(NC, CLW, CHW);
  localparam int EN_BIT = BC_BIT + 1;
  localparam int DM_BIT = BC_BIT + 2;

  logic            full, empty, pop;
  logic [DW-1:0]   head;
  logic [CNTW-1:0] cnt;
  logic            is_dm, en, bc, loc, rem, lfree, rfree, done_pop, done_in;
  logic [CHW-1:0]  tchip;

  dsh_fifo #(.W(DW), .DEPTH(CHK_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .wr_en(chk_valid), .wr_data(chk_data), .full(full),
    .rd_en(pop), .rd_data(head), .empty(empty));

  assign chk_ready  = !full;
  assign done_ready = (cnt != CNTW'(DONE_DEPTH));
  assign is_dm      = head[DM_BIT];
  assign en         = head[EN_BIT];
  assign bc         = head[BC_BIT];
  assign tchip      = head[CH_LSB +: CHW];
  assign loc        = en && (bc || tchip == chip_id);
  assign rem        = en && (bc || tchip != chip_id);
  assign lfree      = !lreq || lgnt;
  assign rfree      = !rreq || rgnt;
  // Pop depends only on this pair's own queues and its own arbiter slots
  assign pop        = !empty && (is_dm || cnt != '0) && (!loc || lfree) && (!rem || rfree);
  assign done_pop   = pop && !is_dm;
  assign done_in    = done_valid && done_ready;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (done_in && !done_pop) cnt <= cnt + 1'b1;
    else if (!done_in && done_pop) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lreq <= 1'b0;
      rreq <= 1'b0;
    end else begin
      if (pop && loc) begin
        lreq  <= 1'b1;
        lcl   <= head[CL_LSB +: CLW];
        lmask <= head[NC-1:0];
      end else if (lgnt) begin
        lreq <= 1'b0;
      end
      if (pop && rem) begin
        rreq  <= 1'b1;
        rchip <= tchip;
        rall  <= bc;
        rcl   <= head[CL_LSB +: CLW];
        rmask <= head[NC-1:0];
      end else if (rgnt) begin
        rreq <= 1'b0;
      end
    end
  end

  assert_done_bound_R11: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNTW'(DONE_DEPTH));
  assert_dummy_keeps_token_R4: assert property (@(posedge clk) disable iff (rst)
    (pop && is_dm && !done_in) |=> $stable(cnt));
  assert_local_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (lreq && !lgnt) |=> (lreq && $stable(lmask) && $stable(lcl)));
  assert_remote_slot_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rreq && !rgnt) |=> (rreq && $stable(rmask) && $stable(rchip)));
endmodule

// File: rtl/dep_signal_hub.sv
module dep_signal_hub #(
  parameter int N_CORES    = 4,
  parameter int N_CLUSTERS = 2,
  parameter int CHIP_W     = 8,
  parameter int DONE_DEPTH = 4,
  parameter int CHK_DEPTH  = 4,
  parameter int DW         = N_CORES + $clog2(N_CLUSTERS) + CHIP_W + 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [CHIP_W-1:0]                    chip_id_i,
  input  logic [N_CORES*N_CLUSTERS-1:0]        done_valid_i,
  output logic [N_CORES*N_CLUSTERS-1:0]        done_ready_o,
  input  logic [N_CORES*N_CLUSTERS-1:0]        chk_valid_i,
  input  logic [N_CORES*N_CLUSTERS*DW-1:0]     chk_data_i,
  output logic [N_CORES*N_CLUSTERS-1:0]        chk_ready_o,
  input  logic                                 in_valid_i,
  output logic                                 in_ready_o,
  input  logic [$clog2(N_CLUSTERS)-1:0]        in_cluster_i,
  input  logic [$clog2(N_CORES)-1:0]           in_col_i,
  input  logic [N_CORES-1:0]                   in_mask_i,
  output logic [N_CORES*N_CLUSTERS-1:0]        set_col_en_o,
  output logic [N_CORES-1:0]                   set_mask_o,
  output logic                                 rem_valid_o,
  input  logic                                 rem_ready_i,
  output logic [CHIP_W-1:0]                    rem_chip_o,
  output logic                                 rem_all_o,
  output logic [$clog2(N_CLUSTERS)-1:0]        rem_cluster_o,
  output logic [$clog2(N_CORES)-1:0]           rem_col_o,
  output logic [N_CORES-1:0]                   rem_mask_o
);
  localparam int NP  = N_CORES * N_CLUSTERS;
  localparam int NA  = NP + 1;
  localparam int CLW = $clog2(N_CLUSTERS);
  localparam int CW  = $clog2(N_CORES);

  logic [NA-1:0]      lreq_v, lgnt;
  logic [NP-1:0]      rreq_v, rreq_m, rgnt;
  logic [CLW-1:0]     acl   [NA];
  logic [CW-1:0]      acol  [NA];
  logic [N_CORES-1:0] amask [NA];
  logic [CHIP_W-1:0]  rchip [NP];
  logic               rall  [NP];
  logic [CLW-1:0]     rcl   [NP];
  logic [N_CORES-1:0] rmsk  [NP];
  logic               rfree;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    dsh_lane #(.NC(N_CORES), .CLW(CLW), .CHW(CHIP_W), .DONE_DEPTH(DONE_DEPTH),
               .CHK_DEPTH(CHK_DEPTH), .DW(DW)) u_lane (
      .clk(clk), .rst(rst), .chip_id(chip_id_i),
      .done_valid(done_valid_i[p]), .done_ready(done_ready_o[p]),
      .chk_valid(chk_valid_i[p]), .chk_data(chk_data_i[p*DW +: DW]),
      .chk_ready(chk_ready_o[p]),
      .lreq(lreq_v[p]), .lcl(acl[p]), .lmask(amask[p]), .lgnt(lgnt[p]),
      .rreq(rreq_v[p]), .rchip(rchip[p]), .rall(rall[p]), .rcl(rcl[p]),
      .rmask(rmsk[p]), .rgnt(rgnt[p]));
    assign acol[p] = CW'(p % N_CORES);
  end

  // Extra arbiter input: signals arriving from other chiplets
  assign lreq_v[NP] = in_valid_i;
  assign acl[NP]    = in_cluster_i;
  assign acol[NP]   = in_col_i;
  assign amask[NP]  = in_mask_i;
  assign in_ready_o = lgnt[NP];

  dsh_rr #(.N(NA)) u_local_arb (
    .clk(clk), .rst(rst), .req(lreq_v), .adv(1'b1), .gnt(lgnt));

  logic [CLW-1:0]     s_cl;
  logic [CW-1:0]      s_col;
  logic [N_CORES-1:0] s_mask;
  always_comb begin
    s_cl = '0; s_col = '0; s_mask = '0;
    for (int i = 0; i < NA; i++) begin
      if (lgnt[i]) begin
        s_cl = acl[i]; s_col = acol[i]; s_mask = amask[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      set_col_en_o <= '0;
      set_mask_o   <= '0;
    end else begin
      set_col_en_o <= '0;
      set_mask_o   <= '0;
      if (|lgnt) begin
        set_col_en_o[int'(s_cl) * N_CORES + int'(s_col)] <= 1'b1;
        set_mask_o <= s_mask;
      end
    end
  end

  // Remote path: arbitrate only when the output register can take a new entry
  assign rfree  = !rem_valid_o || rem_ready_i;
  assign rreq_m = rreq_v & {NP{rfree}};

  dsh_rr #(.N(NP)) u_remote_arb (
    .clk(clk), .rst(rst), .req(rreq_m), .adv(rfree), .gnt(rgnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_valid_o <= 1'b0;
    end else if (rfree) begin
      rem_valid_o <= |rreq_m;
      for (int i = 0; i < NP; i++) begin
        if (rgnt[i]) begin
          rem_chip_o    <= rchip[i];
          rem_all_o     <= rall[i];
          rem_cluster_o <= rcl[i];
          rem_col_o     <= CW'(i % N_CORES);
          rem_mask_o    <= rmsk[i];
        end
      end
    end
  end

  assert_set_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_col_en_o));
  assert_grant_strobes_R6: assert property (@(posedge clk) disable iff (rst)
    (|lgnt) |=> (set_col_en_o != '0));
  assert_remote_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rem_valid_o && !rem_ready_i) |=> (rem_valid_o && $stable(rem_chip_o) &&
      $stable(rem_all_o) && $stable(rem_cluster_o) && $stable(rem_col_o) &&
      $stable(rem_mask_o)));
  assert_in_only_when_valid_R9: assert property (@(posedge clk) disable iff (rst)
    in_ready_o |-> in_valid_i);
endmodule

// File: tb/dep_signal_hub_bench.sv
`timescale 1ns/1ps
module dep_signal_hub_bench;
  localparam int NC = 4, NCL = 2, NP = 8, DW = 16;
  localparam logic [7:0] MYCHIP = 8'h5A;

  logic clk = 1'b0, rst = 1'b1;
  logic [NP-1:0] done_valid = '0, done_ready, chk_valid = '0, chk_ready;
  logic [NP*DW-1:0] chk_data = '0;
  logic in_valid = 1'b0, in_ready;
  logic in_cluster = 1'b0;
  logic [1:0] in_col = '0;
  logic [3:0] in_mask = '0;
  logic [NP-1:0] set_col_en;
  logic [3:0] set_mask;
  logic rem_valid, rem_ready = 1'b1, rem_all, rem_cluster;
  logic [7:0] rem_chip;
  logic [1:0] rem_col;
  logic [3:0] rem_mask;

  dep_signal_hub u_dep_signal_hub (
    .clk(clk), .rst(rst), .chip_id_i(MYCHIP),
    .done_valid_i(done_valid), .done_ready_o(done_ready),
    .chk_valid_i(chk_valid), .chk_data_i(chk_data), .chk_ready_o(chk_ready),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_cluster_i(in_cluster),
    .in_col_i(in_col), .in_mask_i(in_mask),
    .set_col_en_o(set_col_en), .set_mask_o(set_mask),
    .rem_valid_o(rem_valid), .rem_ready_i(rem_ready), .rem_chip_o(rem_chip),
    .rem_all_o(rem_all), .rem_cluster_o(rem_cluster), .rem_col_o(rem_col),
    .rem_mask_o(rem_mask));

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // Event logs sampled at the falling edge
  logic [NP-1:0] ev_col [64];
  logic [3:0]    ev_mask[64];
  int            ev_n = 0;
  logic          rm_all [64];
  logic [3:0]    rm_mask[64];
  logic [1:0]    rm_col [64];
  int            rm_n = 0;

  always @(negedge clk) begin
    if (!rst && set_col_en != '0 && ev_n < 64) begin
      ev_col[ev_n] = set_col_en; ev_mask[ev_n] = set_mask; ev_n++;
    end
    if (!rst && rem_valid && rem_ready && rm_n < 64) begin
      rm_all[rm_n] = rem_all; rm_mask[rm_n] = rem_mask; rm_col[rm_n] = rem_col; rm_n++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] desc(input bit dm, input bit en, input bit bc,
                                       input logic [7:0] chip, input bit cl,
                                       input logic [3:0] mask);
    return {dm, en, bc, chip, cl, mask};
  endfunction

  task automatic push_chk(input int p, input logic [15:0] d);
    chk_data[p*DW +: DW] = d;
    chk_valid[p] = 1'b1;
    @(posedge clk); #1;
    chk_valid[p] = 1'b0;
  endtask

  task automatic push_done(input int p);
    done_valid[p] = 1'b1;
    @(posedge clk); #1;
    done_valid[p] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    check(set_col_en == '0 && set_mask == '0, "R1 strobe idle", int'(set_col_en), 0);
    check(rem_valid == 1'b0, "R1 remote idle", int'(rem_valid), 0);
    check(done_ready == '1 && chk_ready == '1, "R1 queues ready",
          int'({done_ready, chk_ready}), 16'hFFFF);
  endtask

  task automatic t_token_wait();
    int b = ev_n;
    push_chk(5, desc(0, 1, 0, MYCHIP, 0, 4'b0101));
    idle(6);
    check(ev_n == b, "R2 waits for token", ev_n - b, 0);
    push_done(5);
    idle(5);
    check(ev_n == b + 1, "R2 one strobe after token", ev_n - b, 1);
    check(ev_col[b] == 8'b0000_0010, "R6 column bit core1 cluster0", int'(ev_col[b]), 2);
    check(ev_mask[b] == 4'b0101, "R6 row mask", int'(ev_mask[b]), 5);
  endtask

  task automatic t_independent();
    int b = ev_n;
    push_chk(0, desc(0, 1, 0, MYCHIP, 0, 4'b0001));
    push_chk(2, desc(0, 1, 0, MYCHIP, 0, 4'b0100));
    push_done(2);
    idle(5);
    check(ev_n == b + 1 && ev_col[b] == 8'b0000_0100, "R3 other pair proceeds",
          int'(ev_col[b]), 4);
    push_done(0);
    idle(5);
    check(ev_n == b + 2 && ev_col[b+1] == 8'b0000_0001, "R3 blocked pair later",
          int'(ev_col[b+1]), 1);
  endtask

  task automatic t_dummy();
    int b = ev_n;
    push_done(3);
    push_chk(3, desc(1, 1, 0, MYCHIP, 0, 4'b0010));
    push_chk(3, desc(0, 1, 0, MYCHIP, 0, 4'b0100));
    idle(8);
    check(ev_n == b + 2, "R4 dummy leaves token for normal", ev_n - b, 2);
    check(ev_mask[b] == 4'b0010 && ev_mask[b+1] == 4'b0100, "R4 order of strobes",
          int'({ev_mask[b], ev_mask[b+1]}), 8'h24);
    check(ev_col[b] == 8'b0000_1000, "R4 dummy column", int'(ev_col[b]), 8);
  endtask

  task automatic t_disabled();
    int b = ev_n, rb = rm_n;
    push_done(4);
    push_chk(4, desc(0, 0, 1, 8'h11, 1, 4'b1111));
    push_chk(4, desc(0, 1, 0, MYCHIP, 1, 4'b0110));
    idle(8);
    check(ev_n == b && rm_n == rb, "R5 disabled consumed token, no signal",
          ev_n - b + rm_n - rb, 0);
    push_done(4);
    idle(5);
    check(ev_n == b + 1 && ev_col[b] == 8'b0001_0000 && ev_mask[b] == 4'b0110,
          "R5 next entry after new token", int'(ev_col[b]), 16);
  endtask

  task automatic t_remote();
    int b = ev_n, rb = rm_n;
    rem_ready = 1'b0;
    push_chk(6, desc(0, 1, 0, 8'h33, 1, 4'b1000));
    push_done(6);
    idle(5);
    check(rem_valid && rem_chip == 8'h33 && !rem_all && rem_cluster && rem_col == 2'd2
          && rem_mask == 4'b1000, "R7 remote fields", int'(rem_chip), 8'h33);
    idle(3);
    check(rem_valid && rem_chip == 8'h33 && rem_mask == 4'b1000, "R7 held while stalled",
          int'(rem_valid), 1);
    check(ev_n == b, "R7 no local strobe", ev_n - b, 0);
    rem_ready = 1'b1;
    idle(2);
    check(!rem_valid && rm_n == rb + 1, "R7 single transfer", rm_n - rb, 1);
  endtask

  task automatic t_broadcast();
    int b = ev_n, rb = rm_n;
    push_chk(7, desc(0, 1, 1, 8'h00, 0, 4'b0011));
    push_done(7);
    idle(6);
    check(ev_n == b + 1 && ev_col[b] == 8'b0000_1000 && ev_mask[b] == 4'b0011,
          "R8 local part", int'(ev_col[b]), 8);
    check(rm_n == rb + 1 && rm_all[rb] && rm_mask[rb] == 4'b0011 && rm_col[rb] == 2'd3,
          "R8 remote all flag", rm_n - rb, 1);
  endtask

  task automatic t_incoming();
    int b = ev_n, got = 0;
    in_cluster = 1'b1; in_col = 2'd2; in_mask = 4'b1111; in_valid = 1'b1;
    for (int k = 0; k < 10 && got == 0; k++) begin
      @(negedge clk);
      if (in_ready) got = 1;
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    check(got == 1, "R9 accepted", got, 1);
    idle(3);
    check(ev_n == b + 1 && ev_col[b] == 8'b0100_0000 && ev_mask[b] == 4'hF,
          "R9 strobe", int'(ev_col[b]), 64);
  endtask

  task automatic t_round_robin();
    int b = ev_n, seen_in = 0;
    for (int p = 0; p < NP; p++)
      chk_data[p*DW +: DW] = desc(1, 1, 0, MYCHIP, (p >= NC), 4'(1 << (p % NC)));
    chk_valid = '1;
    @(posedge clk); #1;
    chk_valid = '0;
    in_cluster = 1'b0; in_col = 2'd0; in_mask = 4'hF; in_valid = 1'b1;
    for (int k = 0; k < 20 && seen_in == 0; k++) begin
      @(negedge clk);
      if (in_ready) seen_in = 1;
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    idle(12);
    check(ev_n == b + NP + 1, "R10 one grant per input", ev_n - b, NP + 1);
    for (int p = 0; p < NP; p++) begin
      int hits = 0;
      for (int e = b; e < ev_n; e++)
        if (ev_col[e] == 8'(1 << p) && ev_mask[e] == 4'(1 << (p % NC))) hits++;
      check(hits == 1, "R10 pair served once", hits, 1);
    end
    begin
      int hin = 0, multi = 0;
      for (int e = b; e < ev_n; e++) begin
        if (ev_col[e] == 8'b1 && ev_mask[e] == 4'hF) hin++;
        if ($countones(ev_col[e]) != 1) multi++;
      end
      check(hin == 1, "R10 remote input served once", hin, 1);
      check(multi == 0, "R10 single column per strobe", multi, 0);
    end
  endtask

  task automatic t_full();
    int b = ev_n;
    for (int k = 0; k < 4; k++) push_done(0);
    idle(1);
    check(done_ready[0] == 1'b0, "R11 full pair not ready", int'(done_ready[0]), 0);
    check(done_ready[1] == 1'b1, "R11 other pair ready", int'(done_ready[1]), 1);
    for (int k = 0; k < 4; k++) push_chk(0, desc(0, 0, 0, MYCHIP, 0, 4'b0001));
    idle(6);
    check(done_ready[0] == 1'b1, "R11 ready after drain", int'(done_ready[0]), 1);
    check(ev_n == b, "R5 drained entries silent", ev_n - b, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    @(posedge clk); #1;
    t_token_wait();
    t_independent();
    t_dummy();
    t_disabled();
    t_remote();
    t_broadcast();
    t_incoming();
    t_round_robin();
    t_full();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule